// File: doc/BRIEF.md
# Key Event Filter and Change Detector

This block sits behind a matrix keyboard scanner. Each scan delivers one snapshot of up to `SLOTS` pressed keys, each key a scancode made of a row and a column. The block removes snapshots that show ghosting, can move keys to an alternate layer when a designated function key is held, and compares what is left with the key set it accepted last time. It then produces a stream of events: first a release for each key that has gone away, then a press for each key now down, then a sync marker that closes the snapshot.

The accepted set lives in registers inside the block. Key-code translation is left to the consumer: each event carries the scancode plus one layer bit. Snapshots arrive over a valid/ready handshake and events leave over another. A new snapshot is taken only when the previous one has been fully reported.

Top module: `key_event_filter`

## Requirements
- R1: A scancode is `row << COL_W | col`: the column in bits COL_W-1:0 and the row in the bits above. Slot j of `in_codes` is bits `j*CODE_W +: CODE_W`, and it counts only when `in_mask[j]` is 1. `ev_code` is `{layer, scancode}`, with the layer in the MSB.
- R2: If `ghost_en` is 1, at least three keys are counted, some pair of counted keys shares a row and some pair shares a column, then the snapshot is ghosted. It is accepted but produces no events, no sync, and no change to the stored set. `in_ready` stays 1.
- R3: If `ghost_en` is 0, or fewer than three keys are counted, or no row and column coincidences occur together, the snapshot is processed normally.
- R4: If `fn_en` is 1 and a masked slot holds scancode `FN_CODE`, that key is not counted and every counted key gets layer bit 1. This is an offset of rows times columns, which is 2**CODE_W. If `fn_en` is 0, `FN_CODE` is an ordinary key, and the layer bit is 0 whenever the function key is absent.
- R5: Each stored key that is not in the new set produces one release event (`ev_kind` 0). Keys compare with their layer bit. Releases come in stored order, and all come before any press event of the same snapshot.
- R6: Each counted key produces one press event (`ev_kind` 1), in ascending slot order. After the sync handshake the new set replaces the stored set.
- R7: An empty snapshot releases every stored key and leaves the stored set empty.
- R8: Every snapshot that is not ghosted ends with exactly one sync event (`ev_kind` 2, `ev_code` 0), including one that has no other events.
- R9: `in_ready` is 1 only while no snapshot is being reported. Accepting a non-ghosted snapshot drops `in_ready` until the cycle after the sync handshake.
- R10: While `ev_valid` is 1 and `ev_ready` is 0, `ev_valid`, `ev_kind` and `ev_code` hold their values.
- R11: After reset, `in_ready` is 1, `ev_valid` is 0 and the stored set is empty.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ghost_en | input | 1 | Enable ghost rejection |
| fn_en | input | 1 | Enable function-layer mode |
| in_valid | input | 1 | Snapshot valid |
| in_ready | output | 1 | Snapshot accepted this cycle when valid |
| in_mask | input | SLOTS | Per-slot key present flag |
| in_codes | input | SLOTS*CODE_W | Packed slot scancodes |
| ev_valid | output | 1 | Event valid |
| ev_ready | input | 1 | Event consumer ready |
| ev_kind | output | 2 | 0 release, 1 press, 2 sync |
| ev_code | output | CODE_W+1 | Layer bit and scancode |

## Verification
The hardest thing to show from the ports is that a ghosted snapshot left the stored set alone. Such a snapshot produces no events, so the only evidence is in the release list of the snapshot that follows. The stimulus therefore sends two kinds of ghosted snapshot, one with three keys on a corner and one with four keys where the row pair and the column pair are disjoint. It then sends a snapshot that is not filtered, and the scoreboard expects releases taken from the set that was stored before the ghosts. Throttled consumer readiness holds events in stall so that their stability can be checked.

// File: rtl/kef_pkg.sv
package kef_pkg;
   typedef enum logic [1:0] {
      EV_RELEASE = 2'd0,
      EV_PRESS   = 2'd1,
      EV_SYNC    = 2'd2
   } ev_kind_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_REL,
      ST_PRS,
      ST_SYN
   } seq_st_e;
endpackage

// File: rtl/kef_compact.sv
// Drops the function key when layer mode is on and packs kept keys in slot order.
module kef_compact #(
   parameter int          SLOTS   = 8,
   parameter int          CODE_W  = 7,
   parameter int unsigned FN_CODE = 127,
   localparam int         EV_W    = CODE_W + 1,
   localparam int         CNT_W   = $clog2(SLOTS + 1)
) (
   input  logic                      fn_en,
   input  logic [SLOTS-1:0]          mask,
   input  logic [SLOTS*CODE_W-1:0]   codes,
   output logic [SLOTS-1:0]          keep,
   output logic [SLOTS*EV_W-1:0]     list,
   output logic [CNT_W-1:0]          cnt
);
   logic fn_seen;
   int   n;

   always_comb begin
      fn_seen = 1'b0;
      keep    = mask;
      for (int j = 0; j < SLOTS; j++) begin
         if (mask[j] && fn_en && codes[j*CODE_W +: CODE_W] == CODE_W'(FN_CODE)) begin
            keep[j] = 1'b0;
            fn_seen = 1'b1;
         end
      end
      list = '0;
      n    = 0;
      for (int j = 0; j < SLOTS; j++) begin
         if (keep[j]) begin
            list[n*EV_W +: EV_W] = {fn_seen, codes[j*CODE_W +: CODE_W]};
            n = n + 1;
         end
      end
      cnt = CNT_W'(n);
   end
endmodule

// File: rtl/kef_ghost.sv
// Flags a snapshot where some pair shares a row and some pair shares a column.
module kef_ghost #(
   parameter int SLOTS   = 8,
   parameter int CODE_W  = 7,
   parameter int COL_W   = 3,
   parameter bit PRESENT = 1'b1
) (
   input  logic                    en,
   input  logic [SLOTS-1:0]        keep,
   input  logic [SLOTS*CODE_W-1:0] codes,
   output logic                    ghost
);
   if (PRESENT) begin : g_filter
      logic row_hit;
      logic col_hit;
      always_comb begin
         row_hit = 1'b0;
         col_hit = 1'b0;
         for (int j = 0; j < SLOTS; j++) begin
            for (int k = j + 1; k < SLOTS; k++) begin
               if (keep[j] && keep[k]) begin
                  if (codes[j*CODE_W+COL_W +: CODE_W-COL_W] == codes[k*CODE_W+COL_W +: CODE_W-COL_W])
                     row_hit = 1'b1;
                  if (codes[j*CODE_W +: COL_W] == codes[k*CODE_W +: COL_W])
                     col_hit = 1'b1;
               end
            end
         end
         ghost = en && ($countones(keep) >= 3) && row_hit && col_hit;
      end
   end else begin : g_bypass
      logic unused_in;
      assign unused_in = ^{en, keep, codes};
      assign ghost     = 1'b0;
   end
endmodule

// File: rtl/kef_seq.sv
// Holds the stored and the pending set and sequences release, press and sync events.
module kef_seq
   import kef_pkg::*;
#(
   parameter int  SLOTS = 8,
   parameter int  EV_W  = 8,
   localparam int CNT_W = $clog2(SLOTS + 1),
   localparam int IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   acc,
   input  logic [SLOTS*EV_W-1:0]  new_list,
   input  logic [CNT_W-1:0]       new_cnt,
   input  logic                   ev_ready,
   output logic                   idle,
   output logic                   ev_valid,
   output logic [1:0]             ev_kind,
   output logic [EV_W-1:0]        ev_code
);
   seq_st_e           st;
   seq_st_e           leave_st;
   logic [EV_W-1:0]   old_q [SLOTS];
   logic [EV_W-1:0]   nxt_q [SLOTS];
   logic [CNT_W-1:0]  old_cnt;
   logic [CNT_W-1:0]  nxt_cnt;
   logic [SLOTS-1:0]  rel_done;
   logic [SLOTS-1:0]  pend;
   logic [IDX_W-1:0]  pidx;
   logic [IDX_W-1:0]  rel_idx;
   logic              any_pend;
   logic              last_pend;

   // stored keys missing from the new set and not yet reported
   always_comb begin
      for (int i = 0; i < SLOTS; i++) begin
         logic found;
         found = 1'b0;
         for (int k = 0; k < SLOTS; k++)
            if (CNT_W'(k) < nxt_cnt && nxt_q[k] == old_q[i]) found = 1'b1;
         pend[i] = (CNT_W'(i) < old_cnt) && !found && !rel_done[i];
      end
      rel_idx = '0;
      for (int i = SLOTS - 1; i >= 0; i--)
         if (pend[i]) rel_idx = IDX_W'(i);
      any_pend  = |pend;
      last_pend = ($countones(pend) == 1);
      leave_st  = (nxt_cnt == '0) ? ST_SYN : ST_PRS;
   end

   assign idle     = (st == ST_IDLE);
   assign ev_valid = (st == ST_REL && any_pend) || st == ST_PRS || st == ST_SYN;

   always_comb begin
      ev_kind = EV_SYNC;
      ev_code = '0;
      case (st)
         ST_REL: begin ev_kind = EV_RELEASE; ev_code = old_q[rel_idx]; end
         ST_PRS: begin ev_kind = EV_PRESS;   ev_code = nxt_q[pidx];    end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         old_cnt  <= '0;
         nxt_cnt  <= '0;
         rel_done <= '0;
         pidx     <= '0;
         for (int i = 0; i < SLOTS; i++) begin
            old_q[i] <= '0;
            nxt_q[i] <= '0;
         end
      end else begin
         case (st)
            ST_IDLE: if (acc) begin
               for (int i = 0; i < SLOTS; i++) nxt_q[i] <= new_list[i*EV_W +: EV_W];
               nxt_cnt  <= new_cnt;
               rel_done <= '0;
               pidx     <= '0;
               st       <= ST_REL;
            end
            ST_REL: begin
               if (!any_pend) st <= leave_st;
               else if (ev_ready) begin
                  rel_done[rel_idx] <= 1'b1;
                  if (last_pend) st <= leave_st;
               end
            end
            ST_PRS: if (ev_ready) begin
               if (CNT_W'(pidx) + CNT_W'(1) == nxt_cnt) st <= ST_SYN;
               else pidx <= pidx + IDX_W'(1);
            end
            default: if (ev_ready) begin
               for (int i = 0; i < SLOTS; i++) old_q[i] <= nxt_q[i];
               old_cnt <= nxt_cnt;
               st      <= ST_IDLE;
            end
         endcase
      end
   end
endmodule

// File: rtl/key_event_filter.sv
module key_event_filter #(
   parameter int          SLOTS      = 8,
   parameter int          ROW_W      = 4,
   parameter int          COL_W      = 3,
   parameter int unsigned FN_CODE    = 127,
   parameter bit          HAS_GHOST  = 1'b1,
   localparam int         CODE_W     = ROW_W + COL_W,
   localparam int         EV_W       = CODE_W + 1,
   localparam int         CNT_W      = $clog2(SLOTS + 1)
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    ghost_en,
   input  logic                    fn_en,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [SLOTS-1:0]        in_mask,
   input  logic [SLOTS*CODE_W-1:0] in_codes,
   output logic                    ev_valid,
   input  logic                    ev_ready,
   output logic [1:0]              ev_kind,
   output logic [EV_W-1:0]         ev_code
);
   if (SLOTS < 1)  begin : g_bad_slots $error("SLOTS must be at least 1"); end
   if (COL_W < 1 || ROW_W < 1) begin : g_bad_w $error("ROW_W and COL_W must be at least 1"); end
   if (FN_CODE >= (1 << CODE_W)) begin : g_bad_fn $error("FN_CODE exceeds scancode range"); end

   logic [SLOTS-1:0]      keep;
   logic [SLOTS*EV_W-1:0] list;
   logic [CNT_W-1:0]      cnt;
   logic                  ghost_hit;
   logic                  idle;

   kef_compact #(.SLOTS(SLOTS), .CODE_W(CODE_W), .FN_CODE(FN_CODE)) compact_i (
      .fn_en(fn_en), .mask(in_mask), .codes(in_codes),
      .keep(keep), .list(list), .cnt(cnt)
   );

   kef_ghost #(.SLOTS(SLOTS), .CODE_W(CODE_W), .COL_W(COL_W), .PRESENT(HAS_GHOST)) ghost_i (
      .en(ghost_en), .keep(keep), .codes(in_codes), .ghost(ghost_hit)
   );

   kef_seq #(.SLOTS(SLOTS), .EV_W(EV_W)) seq_i (
      .clk(clk), .rst_n(rst_n),
      .acc(in_valid && idle && !ghost_hit),
      .new_list(list), .new_cnt(cnt),
      .ev_ready(ev_ready), .idle(idle),
      .ev_valid(ev_valid), .ev_kind(ev_kind), .ev_code(ev_code)
   );

   assign in_ready = idle;
endmodule

// File: rtl/kef_chk.sv
module kef_chk #(
   parameter int EV_W = 8
) (
   input logic            clk,
   input logic            rst_n,
   input logic            in_valid,
   input logic            in_ready,
   input logic            ev_valid,
   input logic            ev_ready,
   input logic [1:0]      ev_kind,
   input logic [EV_W-1:0] ev_code,
   input logic            ghost_hit
);
   logic press_seen;

   always_ff @(posedge clk) begin
      if (!rst_n) press_seen <= 1'b0;
      else if (ev_valid && ev_ready && ev_kind == 2'd1) press_seen <= 1'b1;
      else if (ev_valid && ev_ready && ev_kind == 2'd2) press_seen <= 1'b0;
   end

   a_r9_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
      ev_valid |-> !in_ready);

   a_r9_accept_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && !ghost_hit) |=> !in_ready);

   a_r2_ghost_dropped: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && ghost_hit) |=> (in_ready && !ev_valid));

   a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && !ev_ready) |=> (ev_valid && $stable(ev_kind) && $stable(ev_code)));

   a_r8_sync_frees: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_ready && ev_kind == 2'd2) |=> in_ready);

   a_r5_release_first: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid && ev_kind == 2'd0) |-> !press_seen);
endmodule

bind key_event_filter kef_chk #(.EV_W(EV_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
   .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind),
   .ev_code(ev_code), .ghost_hit(ghost_hit)
);

// File: tb/key_event_filter_tb_top.sv
module key_event_filter_tb_top;
   localparam int SLOTS = 8;
   localparam int CW    = 7;

   typedef struct {
      logic [1:0] k;
      logic [7:0] c;
      string      tag;
   } exp_t;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             ghost_en = 1'b0;
   logic             fn_en = 1'b0;
   logic             in_valid = 1'b0;
   logic             in_ready;
   logic [SLOTS-1:0] in_mask = '0;
   logic [SLOTS*CW-1:0] in_codes = '0;
   logic             ev_valid;
   logic             ev_ready = 1'b1;
   logic [1:0]       ev_kind;
   logic [7:0]       ev_code;

   int   checks = 0;
   int   fails  = 0;
   bit   stall_on = 1'b0;
   int   cyc = 0;
   exp_t exp_q[$];
   logic [7:0] mdl_q[$];

   always #4 clk = ~clk;

   key_event_filter dut_i (
      .clk(clk), .rst_n(rst_n), .ghost_en(ghost_en), .fn_en(fn_en),
      .in_valid(in_valid), .in_ready(in_ready), .in_mask(in_mask), .in_codes(in_codes),
      .ev_valid(ev_valid), .ev_ready(ev_ready), .ev_kind(ev_kind), .ev_code(ev_code)
   );

   function automatic logic [6:0] sc(int r, int c);
      return 7'((r << 3) | c);
   endfunction

   function automatic logic [55:0] pk(logic [6:0] a, logic [6:0] b, logic [6:0] c, logic [6:0] d,
                                      logic [6:0] e, logic [6:0] f, logic [6:0] g, logic [6:0] h);
      return {h, g, f, e, d, c, b, a};
   endfunction

   task automatic check(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // consumer readiness, changed well after the rising edge
   initial begin
      forever begin
         @(posedge clk);
         #2;
         ev_ready = stall_on ? (cyc % 3 == 0) : 1'b1;
         cyc++;
      end
   end

   // monitor: pops expected events and checks stall stability
   logic       held_v = 1'b0;
   logic [9:0] held_d = '0;
   always @(negedge clk) begin
      if (rst_n) begin
         if (ev_valid && in_ready)
            check(1'b0, "R9", "in_ready while event pending", 1, 0);
         if (held_v) begin
            check(ev_valid && {ev_kind, ev_code} == held_d, "R10", "stalled event changed",
                  int'({ev_valid, ev_kind, ev_code}), int'({1'b1, held_d}));
         end
         if (ev_valid && ev_ready) begin
            if (exp_q.size() == 0) begin
               check(1'b0, "R8", "unexpected event", int'({ev_kind, ev_code}), 0);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               check(ev_kind == e.k && ev_code == e.c, e.tag, "event",
                     int'({ev_kind, ev_code}), int'({e.k, e.c}));
            end
         end
         held_v = ev_valid && !ev_ready;
         held_d = {ev_kind, ev_code};
      end
   end

   // driver: computes expected events from the requirements and sends a snapshot
   task automatic snap(input logic [7:0] m, input logic [55:0] cv, input bit g, input bit f,
                       input string tag);
      logic [6:0] kept[$];
      logic [7:0] nw[$];
      bit fn_seen = 1'b0;
      bit rh = 1'b0;
      bit ch = 1'b0;
      bit ghost;
      for (int j = 0; j < SLOTS; j++) begin
         if (m[j]) begin
            if (f && cv[j*CW +: CW] == 7'h7F) fn_seen = 1'b1;
            else kept.push_back(cv[j*CW +: CW]);
         end
      end
      for (int a = 0; a < kept.size(); a++)
         for (int b = a + 1; b < kept.size(); b++) begin
            if (kept[a][6:3] == kept[b][6:3]) rh = 1'b1;
            if (kept[a][2:0] == kept[b][2:0]) ch = 1'b1;
         end
      ghost = g && kept.size() >= 3 && rh && ch;
      foreach (kept[i]) nw.push_back({fn_seen, kept[i]});
      if (!ghost) begin
         foreach (mdl_q[i]) begin
            bit found = 1'b0;
            foreach (nw[k]) if (nw[k] == mdl_q[i]) found = 1'b1;
            if (!found) exp_q.push_back('{k: 2'd0, c: mdl_q[i], tag: tag});
         end
         foreach (nw[i]) exp_q.push_back('{k: 2'd1, c: nw[i], tag: tag});
         exp_q.push_back('{k: 2'd2, c: 8'h00, tag: tag});
         mdl_q = nw;
      end
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_mask  = m;
      in_codes = cv;
      ghost_en = g;
      fn_en    = f;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      if (ghost) begin
         check(in_ready && !ev_valid, "R2", "ghost snapshot not dropped",
               int'({in_ready, ev_valid}), 2);
      end
      while (exp_q.size() != 0 || !in_ready) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      check(in_ready && !ev_valid, "R11", "reset state", int'({in_ready, ev_valid}), 2);

      snap(8'b0000_0011, pk(sc(1,2), sc(3,4), 0, 0, 0, 0, 0, 0), 0, 0, "R1 R6");
      snap(8'b0010_0001, pk(sc(5,5), 0, 0, 0, 0, sc(3,4), 0, 0), 0, 0, "R5");
      snap(8'b0001_0110, pk(0, sc(2,1), sc(2,3), 0, sc(6,1), 0, 0, 0), 1, 0, "R2");
      snap(8'b1111_0000, pk(0, 0, 0, 0, sc(7,0), sc(7,1), sc(8,5), sc(9,5)), 1, 0, "R2");
      snap(8'b0001_0110, pk(0, sc(2,1), sc(2,3), 0, sc(6,1), 0, 0, 0), 0, 0, "R3");
      snap(8'b0000_0111, pk(sc(0,0), sc(1,1), sc(2,2), 0, 0, 0, 0, 0), 1, 0, "R3");
      snap(8'b0100_1001, pk(sc(4,4), 0, 0, 7'h7F, 0, 0, sc(0,0), 0), 0, 1, "R4");
      snap(8'b0000_0111, pk(sc(3,1), 7'h7F, sc(3,2), 0, 0, 0, 0, 0), 1, 1, "R4");
      snap(8'b0000_0011, pk(7'h7F, sc(1,1), 0, 0, 0, 0, 0, 0), 0, 0, "R4");
      snap(8'b0000_0000, '0, 0, 0, "R7");
      snap(8'b0000_0000, '0, 0, 0, "R8");
      stall_on = 1'b1;
      snap(8'hFF, pk(sc(0,0), sc(1,1), sc(2,2), sc(3,3), sc(4,4), sc(5,5), sc(6,6), sc(7,7)),
           0, 0, "R10");
      snap(8'hFF, pk(sc(8,0), sc(1,1), sc(9,2), sc(3,3), sc(10,4), sc(5,5), sc(11,6), sc(7,7)),
           0, 0, "R5 R9");
      stall_on = 1'b0;
      snap(8'b1000_0000, pk(0, 0, 0, 0, 0, 0, 0, sc(15,7)), 1, 1, "R6");
      repeat (4) @(negedge clk);
      check(exp_q.size() == 0, "R8", "events outstanding", exp_q.size(), 0);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule